// File: doc/BRIEF.md
# Read Data Valid Latency Aligner

This block lives on the controller side of a memory PHY. The controller pulses a read-issue strobe in each cycle in which it launches a read burst. A fixed number of controller clock cycles later, the block raises a read-valid indication that lines up with the returning read data. The PHY reports that number at run time. The block takes it only once, at the first clock edge at which calibration-done is seen high. After that it holds the value until reset, whatever the latency input or the calibration flag do afterwards.

The delay is a tapped shift line, one line per lane. Because of this, any number of reads may be in flight at once, including one in every cycle. In full-rate builds there is a single lane. In half-rate builds each controller word holds two memory beats, and the strobe and the valid are two bits wide. These two bits tell the controller which half of the word holds the first beat, which covers reads that do not start on a word boundary.

The valid output is a plain stream with no ready: returned read data cannot be stalled, so the consumer must take each flagged word in the cycle it appears. The block has no back-pressure path. For the same reason the issue strobe is never refused once the latency is latched.

Top module: `rdv_aligner`

## Requirements
- R1: A synchronous active-high reset clears every pipeline stage and the latched state. In the cycle after reset, rd_valid is all zeros.
- R2: The latency is captured at the first rising clock edge at which cal_done is 1. Later changes of rd_lat have no effect until the next reset.
- R3: rd_valid stays all zeros while no latency is latched. Strobes driven before the capturing edge, including in the cycle where cal_done first goes high, are dropped.
- R4: A nonzero rd_issue driven in cycle c, with latched latency L, appears unchanged on rd_valid in cycle c+L. Cycles in between and cycles without a strobe show all zeros. For example, with L = 9, a strobe in cycle 0 gives valid in cycle 9.
- R5: A captured latency of 0 is treated as 1. A captured latency above DEPTH (default 32) is treated as DEPTH.
- R6: Strobes in consecutive cycles are each reproduced in consecutive cycles, so overlapping reads stay distinct.
- R7: With HALF_RATE = 1 the strobe and the valid are 2 bits wide. Bit 1 marks the first (earlier) half-slot and bit 0 marks the second. A read starting in the second half shows 01, a word-aligned read shows 10, and a full word shows 11. With HALF_RATE = 0 both are 1 bit wide.
- R8: Once the latency is latched, cal_done going low neither unlatches it nor blocks strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous reset, active high |
| cal_done | input | 1 | Calibration finished flag from the PHY |
| rd_lat | input | $clog2(DEPTH+1) | Read latency in controller cycles, reported by the PHY |
| rd_issue | input | LANES | Read-issue strobe, one bit per half-slot |
| rd_valid | output | LANES | Read-valid indication, delayed by the latched latency |

## Verification
Latency capture and strobe acceptance can fall on the same edge. This happens when cal_done first rises in a cycle that also carries a strobe: that strobe must be dropped, while a strobe one cycle later is accepted. A second overlap is a strobe issued in the same cycle as an earlier strobe leaving the line. This is provoked with back-to-back strobes of mixed half-slot patterns at latency 9, at the clamped minimum of 1, and at the clamped maximum of 32. A scoreboard keyed by the due cycle judges each output cycle, for both a half-rate and a full-rate instance.

// File: rtl/rdv_pkg.sv
package rdv_pkg;
  // Lane count per controller word: two half-slots in half-rate mode.
  function automatic int lane_count(input bit half_rate);
    return half_rate ? 2 : 1;
  endfunction
endpackage

// File: rtl/rdv_lat_latch.sv
module rdv_lat_latch #(
  parameter  int DEPTH = 32,
  localparam int LAT_W = $clog2(DEPTH + 1),
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cal_done,
  input  logic [LAT_W-1:0] rd_lat,
  output logic             locked,
  output logic [IDX_W-1:0] sel_q
);
  logic [IDX_W-1:0] sel_d;

  // Clamp into 1..DEPTH, then store as a zero-based tap index.
  always_comb begin
    if (rd_lat == '0)
      sel_d = '0;
    else if (rd_lat > LAT_W'(DEPTH))
      sel_d = IDX_W'(DEPTH - 1);
    else
      sel_d = IDX_W'(rd_lat - LAT_W'(1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      locked <= 1'b0;
      sel_q  <= '0;
    end else if (cal_done && !locked) begin
      locked <= 1'b1;
      sel_q  <= sel_d;
    end
  end
endmodule

// File: rtl/rdv_delay_line.sv
module rdv_delay_line #(
  parameter  int DEPTH = 32,
  parameter  int LANES = 2,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] din,
  input  logic [IDX_W-1:0] sel,
  output logic [LANES-1:0] dout
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [DEPTH-1:0] sr;

    always_ff @(posedge clk) begin
      if (rst) sr <= '0;
      else     sr <= {sr[DEPTH-2:0], din[l]};
    end

    // Stage k holds a strobe issued k+1 cycles earlier.
    assign dout[l] = sr[sel];
  end
endmodule

// File: rtl/rdv_aligner.sv
module rdv_aligner
  import rdv_pkg::*;
#(
  parameter  int DEPTH     = 32,
  parameter  bit HALF_RATE = 1'b1,
  localparam int LANES     = lane_count(HALF_RATE),
  localparam int LAT_W     = $clog2(DEPTH + 1),
  localparam int IDX_W     = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cal_done,
  input  logic [LAT_W-1:0] rd_lat,
  input  logic [LANES-1:0] rd_issue,
  output logic [LANES-1:0] rd_valid
);
  logic             locked;
  logic [IDX_W-1:0] sel_q;
  logic [LANES-1:0] issue_gated;
  logic [LANES-1:0] tap_out;

  rdv_lat_latch #(.DEPTH(DEPTH)) u_latch (
    .clk      (clk),
    .rst      (rst),
    .cal_done (cal_done),
    .rd_lat   (rd_lat),
    .locked   (locked),
    .sel_q    (sel_q)
  );

  // Strobes before the latency is latched never enter the line.
  assign issue_gated = locked ? rd_issue : '0;

  rdv_delay_line #(.DEPTH(DEPTH), .LANES(LANES)) u_line (
    .clk  (clk),
    .rst  (rst),
    .din  (issue_gated),
    .sel  (sel_q),
    .dout (tap_out)
  );

  assign rd_valid = tap_out & {LANES{locked}};
endmodule

// File: rtl/rdv_aligner_chk.sv
module rdv_aligner_chk #(
  parameter int DEPTH = 32,
  parameter int LANES = 2,
  parameter int LAT_W = 6,
  parameter int IDX_W = 5
) (
  input logic             clk,
  input logic             rst,
  input logic             cal_done,
  input logic [LAT_W-1:0] rd_lat,
  input logic [LANES-1:0] rd_issue,
  input logic [LANES-1:0] rd_valid,
  input logic             locked,
  input logic [IDX_W-1:0] sel_q
);
  p_clear_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> rd_valid == '0);

  p_lock_needs_cal_r2: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> $past(cal_done));

  p_sel_frozen_r2: assert property (@(posedge clk) disable iff (rst)
    locked |=> $stable(sel_q) && locked);

  p_quiet_unlocked_r3: assert property (@(posedge clk) disable iff (rst)
    !locked |-> rd_valid == '0);

  p_min_latency_r5: assert property (@(posedge clk) disable iff (rst)
    (locked && sel_q == '0 && rd_issue != '0) |=> rd_valid == $past(rd_issue));

  p_lat_input_unused_r2: assert property (@(posedge clk) disable iff (rst)
    (locked && !$stable(rd_lat)) |-> $stable(sel_q));
endmodule

bind rdv_aligner rdv_aligner_chk #(
  .DEPTH(DEPTH), .LANES(LANES), .LAT_W(LAT_W), .IDX_W(IDX_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cal_done (cal_done),
  .rd_lat   (rd_lat),
  .rd_issue (rd_issue),
  .rd_valid (rd_valid),
  .locked   (locked),
  .sel_q    (sel_q)
);

// File: tb/rdv_aligner_bench.sv
module rdv_aligner_bench;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cal_done = 1'b0;
  logic [5:0] rd_lat = '0;
  logic [1:0] rd_issue = '0;
  logic [1:0] rd_valid;
  logic [0:0] rd_valid_fr;
  logic [0:0] rd_issue_fr;

  always #2 clk = ~clk;

  assign rd_issue_fr = |rd_issue;

  rdv_aligner #(.DEPTH(32), .HALF_RATE(1'b1)) u_rdv_aligner (
    .clk(clk), .rst(rst), .cal_done(cal_done), .rd_lat(rd_lat),
    .rd_issue(rd_issue), .rd_valid(rd_valid));

  rdv_aligner #(.DEPTH(32), .HALF_RATE(1'b0)) u_rdv_aligner_fr (
    .clk(clk), .rst(rst), .cal_done(cal_done), .rd_lat(rd_lat),
    .rd_issue(rd_issue_fr), .rd_valid(rd_valid_fr));

  typedef struct {
    int         due;
    logic [1:0] pat;
    string      tg;
  } item_t;

  item_t exp_q[$];
  int    cyc = 0;
  int    checks = 0;
  int    fails = 0;
  bit    mon_en = 1'b0;
  bit    m_locked = 1'b0;
  int    m_lat = 1;
  string cur_tag = "R1";
  logic [1:0] e_pat;
  string      e_tag;

  always @(posedge clk) cyc <= cyc + 1;

  // Monitor / scoreboard: one comparison per lane width per cycle.
  always @(negedge clk) begin
    if (mon_en) begin
      e_pat = 2'b00;
      e_tag = cur_tag;
      if (exp_q.size() > 0 && exp_q[0].due == cyc) begin
        e_pat = exp_q[0].pat;
        e_tag = exp_q[0].tg;
        void'(exp_q.pop_front());
      end
      checks++;
      if (rd_valid !== e_pat) begin
        fails++;
        $display("FAIL %s half-rate cycle %0d rd_valid=%b expected %b", e_tag, cyc, rd_valid, e_pat);
      end
      checks++;
      if (rd_valid_fr !== (|e_pat)) begin
        fails++;
        $display("FAIL %s/R7 full-rate cycle %0d rd_valid=%b expected %b", e_tag, cyc, rd_valid_fr, |e_pat);
      end
    end
  end

  task automatic step(input logic cal, input logic [5:0] lat, input logic [1:0] iss, input string tg);
    @(negedge clk);
    cal_done = cal;
    rd_lat   = lat;
    rd_issue = iss;
    if (m_locked && iss != 2'b00) exp_q.push_back('{cyc + m_lat, iss, tg});
    if (!m_locked && cal) begin
      m_locked = 1'b1;
      m_lat = (lat == 0) ? 1 : ((lat > 32) ? 32 : int'(lat));
    end
  endtask

  task automatic idle(input int n, input logic cal, input logic [5:0] lat);
    for (int i = 0; i < n; i++) step(cal, lat, 2'b00, "R4");
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    cal_done = 1'b0;
    rd_issue = 2'b00;
    m_locked = 1'b0;
    exp_q.delete();
    repeat (2) @(negedge clk);
    rst = 1'b0;
    cur_tag = "R1";
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL R4 watchdog expired at cycle %0d", cyc);
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    mon_en = 1'b1;
    // R1 reset state, then R3 strobes before calibration are dropped
    step(1'b0, 6'd9, 2'b00, "R1");
    cur_tag = "R3";
    for (int i = 0; i < 6; i++) step(1'b0, 6'd9, 2'b10, "R3");
    // R3: strobe in the very cycle cal_done rises is dropped
    step(1'b1, 6'd9, 2'b11, "R3");
    cur_tag = "R4";
    // R4 single reads, R7 lane patterns
    step(1'b1, 6'd9, 2'b10, "R4");
    idle(3, 1'b1, 6'd9);
    step(1'b1, 6'd9, 2'b01, "R7");
    idle(2, 1'b1, 6'd9);
    // R6 back-to-back overlapping reads with mixed halves
    step(1'b1, 6'd9, 2'b10, "R6");
    step(1'b1, 6'd9, 2'b01, "R6");
    step(1'b1, 6'd9, 2'b11, "R6");
    step(1'b1, 6'd9, 2'b10, "R6");
    // R2 latency input changes after lock are ignored
    step(1'b1, 6'd3, 2'b11, "R2");
    step(1'b1, 6'd0, 2'b01, "R2");
    idle(2, 1'b1, 6'd20);
    // R8 cal_done dropping keeps the lock and accepts strobes
    step(1'b0, 6'd3, 2'b10, "R8");
    step(1'b0, 6'd3, 2'b01, "R8");
    idle(40, 1'b0, 6'd3);

    // R5 zero latency clamps to one
    do_reset();
    step(1'b0, 6'd0, 2'b00, "R1");
    cur_tag = "R5";
    step(1'b1, 6'd0, 2'b00, "R5");
    for (int i = 0; i < 5; i++) step(1'b1, 6'd0, (i % 2 == 0) ? 2'b10 : 2'b01, "R5");
    step(1'b1, 6'd0, 2'b11, "R5");
    idle(5, 1'b1, 6'd0);

    // R5 oversize latency clamps to DEPTH
    do_reset();
    cur_tag = "R5";
    step(1'b1, 6'd45, 2'b00, "R5");
    step(1'b1, 6'd45, 2'b01, "R5");
    step(1'b1, 6'd45, 2'b10, "R5");
    idle(3, 1'b1, 6'd45);
    step(1'b1, 6'd45, 2'b11, "R5");
    idle(40, 1'b1, 6'd45);

    // R4 every expected item was delivered
    checks++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R4 undelivered items=%0d expected 0", exp_q.size());
    end
    summary();
    $finish;
  end
endmodule